// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is the command front end of an I2C master. Software writes 11-bit command words into a transmit queue through a small register port. Each word holds a byte to send, or a request to receive one byte, together with flags that ask for a repeated START before the byte or a STOP after it. The sequencer takes words from the queue and drives a byte-level bus engine through a request/done handshake. It issues START, address, write, read and STOP operations, and it stores received bytes in a receive queue that software drains through the same data offset.

The address phase uses a target register, with either 7-bit or 10-bit addressing. The sequencer inserts a repeated START whenever a word asks for one or the direction changes. If restart is disabled in the control register, it closes the bus with a STOP and reopens it instead. When the queue runs dry in the middle of a transfer, it keeps the bus claimed and waits. An enable bit gates new transfers. Its status copy lags the written value and does not drop while a transfer is still running.

Top module: `i2c_cmd_sequencer`

## Requirements
- R1: A command word pushed by a write to offset 0x10 carries the byte in bits 7:0, a read request in bit 8, STOP-after in bit 9 and restart-before in bit 10. Each queue holds 32 words. Offset 0x74 reads the transmit level and offset 0x78 reads the receive level.
- R2: Each engine operation has a 3-bit code: START=0, ADDR=1, WRITE=2 (data is the byte), READ=3 (data 0) and STOP=4. START and STOP carry data 0. The first word after idle produces START, then ADDR with data {target[6:0], read bit of that word}.
- R3: With control bit 4 set, the address phase is two ADDR operations: {5'b11110, target[9:8], dir}, then target[7:0].
- R4: A read word issues READ. The byte returned with done enters the receive queue, and reads of offset 0x10 return the bytes in order.
- R5: A word with the stop flag is followed by STOP. After the STOP the sequencer goes idle and bit 0 of offset 0x70 reads 0.
- R6: A restart flag, or a direction different from the current one, produces a new START and address phase. If control bit 5 (restart enable) is clear, a STOP comes before that START.
- R7: When the transmit queue empties without a stop, `bus_hold` goes high and activity stays 1. Words pushed later continue the transfer without a new START.
- R8: A push to a full transmit queue is dropped. The level stays at 32 and `tx_ovf_evt` pulses in the cycle after the write.
- R9: A read of offset 0x10 with the receive queue empty returns 0, and `rx_udf_evt` pulses in the cycle after the read.
- R10: Bit 0 of offset 0x6C is the enable bit, and bit 0 of offset 0x9C reports its status 3 clock edges after the write (EN_SYNC_STAGES+1). No transfer starts while the status is 0 or control bit 0 (master) is clear. Clearing the enable during a transfer keeps the status at 1 until activity ends.
- R11: The control register at 0x00 resets to 0x61. The 10-bit target register at 0x04 resets to 0. Writes to either are ignored while the enable status is 1.
- R12: Once a request is raised, it stays asserted with the same operation and data until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at 0x10) |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from reg_addr |
| eng_valid | output | 1 | Operation request to the bus engine |
| eng_op | output | 3 | Operation code |
| eng_data | output | 8 | Address or data byte for the operation |
| eng_done | input | 1 | Engine finished the current operation |
| eng_rdata | input | 8 | Byte received by a READ, valid with eng_done |
| bus_hold | output | 1 | Transfer paused with the bus held, waiting for words |
| tx_ovf_evt | output | 1 | One-cycle pulse: a push was dropped |
| rx_udf_evt | output | 1 | One-cycle pulse: a pop hit an empty queue |

## Verification
Two things can land in the same cycle. The host can pop the receive queue in the cycle the sequencer pushes a fresh byte from a READ, and the host can push the transmit queue in the cycle the sequencer retires a word. The bench provokes both by polling and draining the receive queue during random transfers. It also pushes the second half of each command list while the first half is running. A correct result is a complete engine operation list, matched against a model built from the command words, and a receive byte stream identical to what the engine returned, with no loss or duplication.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
   localparam int CMD_W        = 11;
   localparam int CMD_RD_BIT   = 8;
   localparam int CMD_STOP_BIT = 9;
   localparam int CMD_RS_BIT   = 10;
   localparam int TGT_W        = 10;
   localparam int CTL_W        = 7;

   localparam int CTL_MASTER   = 0;
   localparam int CTL_TENBIT   = 4;
   localparam int CTL_RSTEN    = 5;
   localparam logic [CTL_W-1:0] CTL_RESET = 7'h61;

   localparam logic [7:0] OFS_CTRL   = 8'h00;
   localparam logic [7:0] OFS_TARGET = 8'h04;
   localparam logic [7:0] OFS_FIFO   = 8'h10;
   localparam logic [7:0] OFS_ENABLE = 8'h6C;
   localparam logic [7:0] OFS_STATUS = 8'h70;
   localparam logic [7:0] OFS_TXLVL  = 8'h74;
   localparam logic [7:0] OFS_RXLVL  = 8'h78;
   localparam logic [7:0] OFS_ENSTAT = 8'h9C;

   typedef enum logic [2:0] {
      OP_START = 3'd0,
      OP_ADDR  = 3'd1,
      OP_WRITE = 3'd2,
      OP_READ  = 3'd3,
      OP_STOP  = 3'd4
   } bus_op_e;
endpackage

// File: rtl/i2c_seq_fifo.sv
module i2c_seq_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [WIDTH-1:0]             wdata,
   input  logic                         pop,
   output logic [WIDTH-1:0]             head,
   output logic                         full,
   output logic                         empty,
   output logic [$clog2(DEPTH+1)-1:0]   level
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int LVL_W = $clog2(DEPTH+1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("i2c_seq_fifo: DEPTH must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("i2c_seq_fifo: WIDTH must be positive");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic             do_push, do_pop;

   assign full    = (level == LVL_W'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rd_ptr];

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= bump(wr_ptr);
         if (do_pop)  rd_ptr <= bump(rd_ptr);
         if (do_push && !do_pop)      level <= level + 1'b1;
         else if (do_pop && !do_push) level <= level - 1'b1;
      end
   end
endmodule

// File: rtl/i2c_seq_ensync.sv
module i2c_seq_ensync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_req,
   input  logic busy,
   output logic en_sync,
   output logic en_stat
);
   if (STAGES < 1) begin : g_bad_stages
      $error("i2c_seq_ensync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= en_req;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], en_req};
      end
   end

   assign en_sync = chain[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_stat <= 1'b0;
      else        en_stat <= en_sync | (en_stat & busy);
   end
endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
   import i2c_seq_pkg::*;
#(
   parameter int TW = TGT_W
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           launch_ok,
   input  logic           ten_bit,
   input  logic           restart_ok,
   input  logic [TW-1:0]  target,
   input  logic [CMD_W-1:0] head,
   input  logic           tx_empty,
   input  logic           rx_full,
   output logic           tx_pop,
   output logic           rx_push,
   output logic           req,
   output bus_op_e        op,
   output logic [7:0]     op_data,
   input  logic           done,
   output logic           active,
   output logic           hold
);
   if (TW < 10) begin : g_bad_tw
      $error("i2c_seq_fsm: target width must cover 10-bit addresses");
   end

   typedef enum logic [2:0] {
      S_IDLE, S_START, S_ADDR_HI, S_ADDR_LO, S_XFER, S_GAP, S_STOP
   } seq_state_e;

   seq_state_e state_q, state_d;
   logic       dir_q, dir_d;
   logic       relaunch_q, relaunch_d;

   logic head_rd, head_stop, head_rs, turn;
   assign head_rd   = head[CMD_RD_BIT];
   assign head_stop = head[CMD_STOP_BIT];
   assign head_rs   = head[CMD_RS_BIT];
   assign turn      = head_rs || (head_rd != dir_q);

   always_comb begin
      state_d    = state_q;
      dir_d      = dir_q;
      relaunch_d = relaunch_q;
      req        = 1'b0;
      op         = OP_START;
      op_data    = '0;
      tx_pop     = 1'b0;
      rx_push    = 1'b0;
      case (state_q)
         S_IDLE: begin
            if (launch_ok && !tx_empty) begin
               state_d = S_START;
               dir_d   = head_rd;
            end
         end
         S_START: begin
            req = 1'b1;
            op  = OP_START;
            if (done) state_d = S_ADDR_HI;
         end
         S_ADDR_HI: begin
            req     = 1'b1;
            op      = OP_ADDR;
            op_data = ten_bit ? {5'b11110, target[9:8], dir_q}
                              : {target[6:0], dir_q};
            if (done) state_d = ten_bit ? S_ADDR_LO : S_XFER;
         end
         S_ADDR_LO: begin
            req     = 1'b1;
            op      = OP_ADDR;
            op_data = target[7:0];
            if (done) state_d = S_XFER;
         end
         S_XFER: begin
            req     = !tx_empty && !(head_rd && rx_full);
            op      = head_rd ? OP_READ : OP_WRITE;
            op_data = head_rd ? 8'h00 : head[7:0];
            if (req && done) begin
               tx_pop  = 1'b1;
               rx_push = head_rd;
               state_d = head_stop ? S_STOP : S_GAP;
            end
         end
         S_GAP: begin
            if (!tx_empty) begin
               if (!turn) begin
                  state_d = S_XFER;
               end else if (restart_ok) begin
                  state_d = S_START;
                  dir_d   = head_rd;
               end else begin
                  state_d    = S_STOP;
                  relaunch_d = 1'b1;
               end
            end
         end
         S_STOP: begin
            req = 1'b1;
            op  = OP_STOP;
            if (done) begin
               if (relaunch_q) begin
                  relaunch_d = 1'b0;
                  dir_d      = head_rd;
                  state_d    = S_START;
               end else begin
                  state_d = S_IDLE;
               end
            end
         end
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= S_IDLE;
         dir_q      <= 1'b0;
         relaunch_q <= 1'b0;
      end else begin
         state_q    <= state_d;
         dir_q      <= dir_d;
         relaunch_q <= relaunch_d;
      end
   end

   assign active = (state_q != S_IDLE);
   assign hold   = (state_q == S_GAP) && tx_empty;
endmodule

// File: rtl/i2c_cmd_sequencer.sv
module i2c_cmd_sequencer
   import i2c_seq_pkg::*;
#(
   parameter int ADDR_W         = 8,
   parameter int DATA_W         = 32,
   parameter int TX_DEPTH       = 32,
   parameter int RX_DEPTH       = 32,
   parameter int EN_SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              eng_valid,
   output logic [2:0]        eng_op,
   output logic [7:0]        eng_data,
   input  logic              eng_done,
   input  logic [7:0]        eng_rdata,
   output logic              bus_hold,
   output logic              tx_ovf_evt,
   output logic              rx_udf_evt
);
   localparam int TX_LVL_W = $clog2(TX_DEPTH+1);
   localparam int RX_LVL_W = $clog2(RX_DEPTH+1);

   if (ADDR_W < 8) begin : g_bad_addr
      $error("i2c_cmd_sequencer: ADDR_W must hold an 8-bit offset");
   end
   if (DATA_W < CMD_W) begin : g_bad_data
      $error("i2c_cmd_sequencer: DATA_W must hold a command word");
   end

   logic [CTL_W-1:0] ctrl_q;
   logic [TGT_W-1:0] target_q;
   logic             en_reg_q;
   logic             en_sync, en_stat;

   logic                tx_push, tx_pop, tx_full, tx_empty;
   logic [CMD_W-1:0]    tx_head;
   logic [TX_LVL_W-1:0] tx_level;
   logic                rx_push, rx_pop, rx_full, rx_empty;
   logic [7:0]          rx_head;
   logic [RX_LVL_W-1:0] rx_level;

   logic    seq_active, seq_req;
   bus_op_e seq_op;

   logic hit_fifo;
   assign hit_fifo = (reg_addr == ADDR_W'(OFS_FIFO));
   assign tx_push  = reg_wr && hit_fifo;
   assign rx_pop   = reg_rd && hit_fifo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q     <= CTL_RESET;
         target_q   <= '0;
         en_reg_q   <= 1'b0;
         tx_ovf_evt <= 1'b0;
         rx_udf_evt <= 1'b0;
      end else begin
         if (reg_wr && !en_stat && reg_addr == ADDR_W'(OFS_CTRL))
            ctrl_q <= reg_wdata[CTL_W-1:0];
         if (reg_wr && !en_stat && reg_addr == ADDR_W'(OFS_TARGET))
            target_q <= reg_wdata[TGT_W-1:0];
         if (reg_wr && reg_addr == ADDR_W'(OFS_ENABLE))
            en_reg_q <= reg_wdata[0];
         tx_ovf_evt <= tx_push && tx_full;
         rx_udf_evt <= rx_pop && rx_empty;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(OFS_CTRL):   reg_rdata = DATA_W'(ctrl_q);
         ADDR_W'(OFS_TARGET): reg_rdata = DATA_W'(target_q);
         ADDR_W'(OFS_FIFO):   reg_rdata = rx_empty ? '0 : DATA_W'(rx_head);
         ADDR_W'(OFS_ENABLE): reg_rdata = DATA_W'(en_reg_q);
         ADDR_W'(OFS_STATUS): reg_rdata = DATA_W'(seq_active);
         ADDR_W'(OFS_TXLVL):  reg_rdata = DATA_W'(tx_level);
         ADDR_W'(OFS_RXLVL):  reg_rdata = DATA_W'(rx_level);
         ADDR_W'(OFS_ENSTAT): reg_rdata = DATA_W'(en_stat);
         default:             reg_rdata = '0;
      endcase
   end

   i2c_seq_fifo #(.WIDTH(CMD_W), .DEPTH(TX_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .push(tx_push), .wdata(reg_wdata[CMD_W-1:0]),
      .pop(tx_pop), .head(tx_head),
      .full(tx_full), .empty(tx_empty), .level(tx_level)
   );

   i2c_seq_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push(rx_push), .wdata(eng_rdata),
      .pop(rx_pop), .head(rx_head),
      .full(rx_full), .empty(rx_empty), .level(rx_level)
   );

   i2c_seq_ensync #(.STAGES(EN_SYNC_STAGES)) u_en (
      .clk(clk), .rst_n(rst_n),
      .en_req(en_reg_q), .busy(seq_active),
      .en_sync(en_sync), .en_stat(en_stat)
   );

   i2c_seq_fsm #(.TW(TGT_W)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .launch_ok(en_stat && en_sync && ctrl_q[CTL_MASTER]),
      .ten_bit(ctrl_q[CTL_TENBIT]),
      .restart_ok(ctrl_q[CTL_RSTEN]),
      .target(target_q),
      .head(tx_head), .tx_empty(tx_empty), .rx_full(rx_full),
      .tx_pop(tx_pop), .rx_push(rx_push),
      .req(seq_req), .op(seq_op), .op_data(eng_data),
      .done(eng_done),
      .active(seq_active), .hold(bus_hold)
   );

   assign eng_valid = seq_req;
   assign eng_op    = seq_op;
endmodule

// File: rtl/i2c_seq_checker.sv
module i2c_seq_checker
   import i2c_seq_pkg::*;
#(
   parameter int TX_DEPTH = 32,
   parameter int RX_DEPTH = 32,
   parameter int TX_LVL_W = 6,
   parameter int RX_LVL_W = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req,
   input logic                done,
   input logic [2:0]          op,
   input logic [7:0]          op_data,
   input logic                active,
   input logic                hold,
   input logic                en_stat,
   input logic                en_sync,
   input logic [TX_LVL_W-1:0] tx_level,
   input logic [RX_LVL_W-1:0] rx_level
);
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      req && !done |=> req && $stable(op) && $stable(op_data)); // R12
   AST_TX_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      tx_level <= TX_LVL_W'(TX_DEPTH)); // R8
   AST_RX_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      rx_level <= RX_LVL_W'(RX_DEPTH)); // R4
   AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> active && !req); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !req); // R5
   AST_START_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> req && op == 3'(OP_START)); // R2
   AST_EN_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_stat) |-> !$past(active)); // R10
   AST_EN_RISE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_stat) |-> $past(en_sync)); // R10
endmodule

bind i2c_cmd_sequencer i2c_seq_checker #(
   .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH),
   .TX_LVL_W(TX_LVL_W), .RX_LVL_W(RX_LVL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .req(eng_valid), .done(eng_done), .op(eng_op), .op_data(eng_data),
   .active(seq_active), .hold(bus_hold),
   .en_stat(en_stat), .en_sync(en_sync),
   .tx_level(tx_level), .rx_level(rx_level)
);

// File: tb/tb_i2c_cmd_sequencer.sv
`timescale 1ns/1ps
module tb_i2c_cmd_sequencer;
   localparam int EN_LAG = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        eng_valid;
   logic [2:0]  eng_op;
   logic [7:0]  eng_data;
   logic        eng_done = 1'b0;
   logic [7:0]  eng_rdata = '0;
   logic        bus_hold, tx_ovf_evt, rx_udf_evt;

   int nchk = 0, nerr = 0;
   logic [10:0] cmd_q[$];
   logic [10:0] exp_q[$];
   logic [10:0] got_q[$];
   logic [7:0]  eng_rx_q[$];

   i2c_cmd_sequencer dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .eng_valid(eng_valid), .eng_op(eng_op), .eng_data(eng_data),
      .eng_done(eng_done), .eng_rdata(eng_rdata),
      .bus_hold(bus_hold), .tx_ovf_evt(tx_ovf_evt), .rx_udf_evt(rx_udf_evt)
   );

   always #2.5 clk = ~clk;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp, input string what);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // bus engine model: random latency, records completed operations
   initial begin
      int lat;
      int rd_cnt;
      logic [10:0] prev;
      bit pend;
      lat = 1; rd_cnt = 0; pend = 0; prev = '0;
      forever begin
         @(negedge clk);
         if (eng_done) begin
            eng_done = 1'b0;
            pend = 0;
         end else if (eng_valid) begin
            if (pend)
               check({eng_op, eng_data} == prev, "R12", {eng_op, eng_data}, prev,
                     "request changed before done");
            prev = {eng_op, eng_data};
            pend = 1;
            if (lat == 0) begin
               got_q.push_back({eng_op, eng_data});
               if (eng_op == 3'd3) begin
                  eng_rdata = 8'h5A ^ 8'(rd_cnt * 37);
                  eng_rx_q.push_back(eng_rdata);
                  rd_cnt++;
               end
               eng_done = 1'b1;
               lat = $urandom % 3;
            end else lat--;
         end else pend = 0;
      end
   end

   task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic push_cmd(input logic [10:0] c);
      cmd_q.push_back(c);
      reg_write(8'h10, {21'b0, c});
   endtask

   task automatic set_enable(input bit v);
      logic [31:0] s;
      reg_write(8'h6C, {31'b0, v});
      for (int i = 0; i < 100; i++) begin
         reg_read(8'h9C, s);
         if (s[0] == v) break;
      end
   endtask

   task automatic emit_addr(input logic [9:0] tar, input bit ten, input bit dir);
      if (ten) begin
         exp_q.push_back({3'd1, 5'b11110, tar[9:8], dir});
         exp_q.push_back({3'd1, tar[7:0]});
      end else exp_q.push_back({3'd1, tar[6:0], dir});
   endtask

   // builds the expected engine operation list from the queued command words
   task automatic model(input logic [9:0] tar, input bit ten, input bit rsen);
      bit idle;
      bit dir;
      idle = 1; dir = 0;
      foreach (cmd_q[i]) begin
         logic [10:0] c;
         c = cmd_q[i];
         if (idle) begin
            exp_q.push_back({3'd0, 8'h00});
            dir = c[8];
            emit_addr(tar, ten, dir);
            idle = 0;
         end else if (c[10] || c[8] != dir) begin
            if (!rsen) exp_q.push_back({3'd4, 8'h00});
            exp_q.push_back({3'd0, 8'h00});
            dir = c[8];
            emit_addr(tar, ten, dir);
         end
         exp_q.push_back(c[8] ? {3'd3, 8'h00} : {3'd2, c[7:0]});
         if (c[9]) begin
            exp_q.push_back({3'd4, 8'h00});
            idle = 1;
         end
      end
      cmd_q.delete();
   endtask

   task automatic pop_one();
      logic [31:0] b;
      logic [7:0]  e;
      reg_read(8'h10, b);
      e = (eng_rx_q.size() > 0) ? eng_rx_q.pop_front() : 8'hxx;
      check(b[7:0] === e, "R4", b, {24'b0, e}, "received byte order");
   endtask

   task automatic wait_idle_drain();
      logic [31:0] s, t, r;
      for (int i = 0; i < 2000; i++) begin
         reg_read(8'h78, r);
         if (r != 0) pop_one();
         reg_read(8'h70, s);
         reg_read(8'h74, t);
         if (s == 0 && t == 0) break;
      end
      reg_read(8'h78, r);
      for (int i = 0; i < int'(r); i++) pop_one();
      check(eng_rx_q.size() == 0, "R4", eng_rx_q.size(), 0, "bytes left undelivered");
   endtask

   task automatic compare_ops(input string req);
      int n;
      check(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size(), "operation count");
      n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
      for (int i = 0; i < n; i++)
         check(got_q[i] == exp_q[i], req, {21'b0, got_q[i]}, {21'b0, exp_q[i]},
               $sformatf("operation %0d", i));
      got_q.delete();
      exp_q.delete();
   endtask

   task automatic finish_txn(input logic [9:0] tar, input bit ten, input bit rsen,
                             input string req);
      model(tar, ten, rsen);
      wait_idle_drain();
      compare_ops(req);
   endtask

   initial begin
      #(5.0 * 150000);
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int k;
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      reg_read(8'h00, v); check(v == 32'h61, "R11", v, 32'h61, "control reset");
      reg_read(8'h04, v); check(v == 0, "R11", v, 0, "target reset");
      reg_read(8'h74, v); check(v == 0, "R1", v, 0, "tx level reset");
      reg_read(8'h78, v); check(v == 0, "R1", v, 0, "rx level reset");
      reg_read(8'h70, v); check(v == 0, "R5", v, 0, "activity reset");
      reg_read(8'h9C, v); check(v == 0, "R10", v, 0, "enable status reset");
      reg_read(8'h10, v); check(v == 0, "R9", v, 0, "empty pop data");
      check(rx_udf_evt == 1'b1, "R9", rx_udf_evt, 1, "underflow pulse");
      @(negedge clk); check(rx_udf_evt == 1'b0, "R9", rx_udf_evt, 0, "underflow pulse width");

      // words wait while disabled
      reg_write(8'h04, 32'h52);
      push_cmd(11'h03C);
      push_cmd(11'h2C3);
      repeat (20) @(negedge clk);
      reg_read(8'h74, v); check(v == 2, "R1", v, 2, "tx level with two words");
      check(got_q.size() == 0, "R10", got_q.size(), 0, "no operation while disabled");

      // enable status lag
      reg_write(8'h6C, 32'h1);
      reg_rd = 1'b1; reg_addr = 8'h9C;
      #1 k = 0;
      while (!reg_rdata[0] && k < 20) begin @(negedge clk); #1 k++; end
      reg_rd = 1'b0;
      check(k == EN_LAG, "R10", k, EN_LAG, "enable status lag");
      finish_txn(10'h52, 0, 1, "R2");

      // configuration locked while enabled
      reg_write(8'h04, 32'h11);
      reg_read(8'h04, v); check(v == 32'h52, "R11", v, 32'h52, "target write ignored");
      reg_write(8'h00, 32'h00);
      reg_read(8'h00, v); check(v == 32'h61, "R11", v, 32'h61, "control write ignored");

      // direction change forces restart, reads land in rx queue
      push_cmd(11'h012); push_cmd(11'h100); push_cmd(11'h300);
      finish_txn(10'h52, 0, 1, "R6");

      // explicit restart, same direction
      push_cmd(11'h0A1); push_cmd(11'h6A2);
      finish_txn(10'h52, 0, 1, "R6");

      // queue runs dry: bus held, enable drop deferred
      push_cmd(11'h077);
      repeat (30) @(negedge clk);
      check(bus_hold == 1'b1, "R7", bus_hold, 1, "hold while waiting");
      reg_read(8'h70, v); check(v == 1, "R7", v, 1, "activity while holding");
      reg_write(8'h6C, 32'h0);
      repeat (10) @(negedge clk);
      reg_read(8'h9C, v); check(v == 1, "R10", v, 1, "status kept during transfer");
      push_cmd(11'h288);
      finish_txn(10'h52, 0, 1, "R7");
      for (int i = 0; i < 20; i++) begin reg_read(8'h9C, v); if (v == 0) break; end
      check(v == 0, "R10", v, 0, "status drops after transfer");

      // restart disabled: STOP then START
      reg_write(8'h00, 32'h41);
      reg_read(8'h00, v); check(v == 32'h41, "R11", v, 32'h41, "control write while disabled");
      set_enable(1);
      push_cmd(11'h001); push_cmd(11'h300);
      finish_txn(10'h52, 0, 0, "R6");

      // 10-bit addressing
      set_enable(0);
      reg_write(8'h00, 32'h71);
      reg_write(8'h04, 32'h2A5);
      set_enable(1);
      push_cmd(11'h25E);
      finish_txn(10'h2A5, 1, 1, "R3");

      // overflow of the transmit queue
      set_enable(0);
      reg_write(8'h00, 32'h61);
      reg_write(8'h04, 32'h33);
      for (int i = 0; i < 32; i++) push_cmd((i == 31) ? 11'h200 | 11'(i) : 11'(i));
      check(tx_ovf_evt == 1'b0, "R8", tx_ovf_evt, 0, "no overflow at 32");
      reg_read(8'h74, v); check(v == 32, "R1", v, 32, "tx queue depth");
      reg_write(8'h10, 32'h0FF);
      check(tx_ovf_evt == 1'b1, "R8", tx_ovf_evt, 1, "overflow pulse");
      reg_read(8'h74, v); check(v == 32, "R8", v, 32, "level after dropped push");
      set_enable(1);
      finish_txn(10'h33, 0, 1, "R8");

      // random transfers with concurrent host traffic
      for (int t = 0; t < 12; t++) begin
         int n;
         bit rsen;
         logic [9:0] tar;
         n = 1 + ($urandom % 6);
         rsen = $urandom % 2;
         tar = 10'($urandom % 128);
         set_enable(0);
         reg_write(8'h00, rsen ? 32'h61 : 32'h41);
         reg_write(8'h04, {22'b0, tar});
         set_enable(1);
         for (int i = 0; i < n; i++) begin
            logic [10:0] c;
            c[7:0] = 8'($urandom);
            c[8]   = $urandom % 2;
            c[9]   = (i == n - 1) || (($urandom % 8) == 0);
            c[10]  = ($urandom % 4) == 0;
            push_cmd(c);
            if (i == n / 2) repeat (3) @(negedge clk);
         end
         finish_txn(tar, 0, rsen, "R5");
      end

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule